// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A register-mapped watchdog that a supervisor program must service regularly. An internal prescaler divides the clock into a fixed tick. On each tick, a down-counter loaded from a programmable initial value steps toward zero. A tick that arrives while the count is zero is an expiry, and the counter then reloads.

The first expiry only raises a first-timeout status flag, which is write-1-to-clear. If a second expiry arrives while that flag is still set, the block records a second-timeout status and issues a one-cycle reset request. A no-reboot control bit can hold back that request. When the request does go out, a boot-status flag is set, so software can tell after restart that the watchdog caused it.

Software stops or starts the count with a halt bit. It services the watchdog by writing a fixed key to the count register. Initial values below four are refused.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the halt bit and the no-reboot bit are 1, every status bit is 0, the initial value is 4, the live count is 4 and `rst_req_o` is 0.
- R2: While running, the count falls by one every `TICK_CYCLES` clocks, and a read of address 0x00 returns the live count in its low bits.
- R3: Bit 11 of the control register at 0x08 is the halt bit and reads back as written. While it is 1 the count and the prescaler phase hold still, with the phase held at zero.
- R4: Writing exactly 0x0001 to address 0x00 loads the count from the initial value, and other data at that address has no effect. A reload in the same cycle as an expiry wins, and no expiry is counted.
- R5: The initial value is a 10-bit field at address 0x12 (a 6-bit field at 0x01 when `WIDE` is 0). A write whose field is 0 to 3 is refused and the old value kept, and the bits above the field read 0.
- R6: A tick that arrives while the count is 0 is an expiry. The count reloads, and bit 3 at address 0x04 (first timeout) is set if it was clear.
- R7: Status bits are write-1-to-clear, and writing 0 to a status bit leaves it unchanged.
- R8: An expiry while bit 3 of 0x04 is set sets bit 1 of 0x06 (second timeout). With no-reboot clear, it also raises `rst_req_o` for exactly one clock, in the cycle after the expiring edge.
- R9: Bit 0 of 0x08 is the no-reboot bit. While it is 1, a second expiry still sets bit 1 of 0x06 but produces no pulse on `rst_req_o`.
- R10: Bit 2 of 0x06 (boot status) is set whenever a reset request is issued, and is write-1-to-clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Register address |
| we_i | input | 1 | Write strobe, takes effect at the rising edge |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The count is run from several initial values, which separates an off-by-one in the tick divide from one in the zero-crossing reload. The escalation is driven three ways: with no-reboot set, with no-reboot clear, and with the first flag cleared between expiries. Together these separate status recording from gating of the request. One reload is placed on the exact edge of an expiry, which shows whether reload priority suppresses the first-timeout flag. Refused initial values and non-key writes to the count register are followed by read-backs, which show that nothing changed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_RELOAD      = 5'h00;
  localparam logic [ADDR_W-1:0] A_INIT_NARROW = 5'h01;
  localparam logic [ADDR_W-1:0] A_STS1        = 5'h04;
  localparam logic [ADDR_W-1:0] A_STS2        = 5'h06;
  localparam logic [ADDR_W-1:0] A_CTRL        = 5'h08;
  localparam logic [ADDR_W-1:0] A_INIT_WIDE   = 5'h12;

  localparam int HALT_BIT     = 11;
  localparam int NOREBOOT_BIT = 0;
  localparam int FIRST_BIT    = 3;
  localparam int SECOND_BIT   = 1;
  localparam int BOOT_BIT     = 2;

  localparam int MIN_INIT = 4;
  localparam logic [DATA_W-1:0] RELOAD_KEY = 16'h0001;

  typedef struct packed {
    logic first;
    logic second;
    logic boot;
  } wdt_sts_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pc_q;

  assign tick_o = run_i && (pc_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= '0;
    else if (!run_i || tick_o)  pc_q <= '0;  // halt parks the phase at zero
    else                        pc_q <= pc_q + PW'(1);
  end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  // reload in the same cycle masks the expiry
  assign expire_o = tick_i && !reload_i && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= CNT_W'(MIN_INIT);
    else if (reload_i || expire_o) cnt_q <= init_i;
    else if (tick_i)              cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/wdt_escalation.sv
module wdt_escalation (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expire_i,
  input  logic              block_i,
  input  wdt_pkg::wdt_sts_t clr_i,
  output wdt_pkg::wdt_sts_t sts_o,
  output logic              rst_req_o
);
  import wdt_pkg::*;

  wdt_sts_t sts_q;
  logic     second_hit, fire;

  assign second_hit = expire_i && sts_q.first;
  assign fire       = second_hit && !block_i;
  assign sts_o      = sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q     <= '0;
      rst_req_o <= 1'b0;
    end else begin
      sts_q.first  <= (sts_q.first  && !clr_i.first)  || (expire_i && !sts_q.first);
      sts_q.second <= (sts_q.second && !clr_i.second) || second_hit;
      sts_q.boot   <= (sts_q.boot   && !clr_i.boot)   || fire;
      rst_req_o    <= fire;
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int TICK_CYCLES = 4,
  parameter bit WIDE        = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  addr_i,
  input  logic        we_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        rst_req_o
);
  import wdt_pkg::*;

  localparam int CNT_W = WIDE ? 10 : 6;
  localparam logic [ADDR_W-1:0] INIT_ADDR = WIDE ? A_INIT_WIDE : A_INIT_NARROW;

  logic             halt_q, no_reboot_q;
  logic [CNT_W-1:0] init_q, cnt;
  logic             tick, expire, reload_req, init_wr, ctrl_wr;
  wdt_sts_t         clr, sts;

  assign reload_req = we_i && (addr_i == A_RELOAD) && (wdata_i == RELOAD_KEY);
  assign init_wr    = we_i && (addr_i == INIT_ADDR) &&
                      (wdata_i[CNT_W-1:0] >= CNT_W'(MIN_INIT));
  assign ctrl_wr    = we_i && (addr_i == A_CTRL);

  assign clr.first  = we_i && (addr_i == A_STS1) && wdata_i[FIRST_BIT];
  assign clr.second = we_i && (addr_i == A_STS2) && wdata_i[SECOND_BIT];
  assign clr.boot   = we_i && (addr_i == A_STS2) && wdata_i[BOOT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q      <= 1'b1;
      no_reboot_q <= 1'b1;
      init_q      <= CNT_W'(MIN_INIT);
    end else begin
      if (ctrl_wr) begin
        halt_q      <= wdata_i[HALT_BIT];
        no_reboot_q <= wdata_i[NOREBOOT_BIT];
      end
      if (init_wr) init_q <= wdata_i[CNT_W-1:0];
    end
  end

  wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!halt_q),
    .tick_o (tick)
  );

  wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .reload_i (reload_req),
    .init_i   (init_q),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  wdt_escalation u_esc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .block_i   (no_reboot_q),
    .clr_i     (clr),
    .sts_o     (sts),
    .rst_req_o (rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_RELOAD)       rdata_o = DATA_W'(cnt);
    else if (addr_i == INIT_ADDR) rdata_o = DATA_W'(init_q);
    else if (addr_i == A_STS1)    rdata_o[FIRST_BIT] = sts.first;
    else if (addr_i == A_STS2) begin
      rdata_o[SECOND_BIT] = sts.second;
      rdata_o[BOOT_BIT]   = sts.boot;
    end else if (addr_i == A_CTRL) begin
      rdata_o[HALT_BIT]     = halt_q;
      rdata_o[NOREBOOT_BIT] = no_reboot_q;
    end
  end
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_req_i,
  input logic             halt_i,
  input logic             no_reboot_i,
  input logic             reload_i,
  input logic             first_i,
  input logic             second_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] init_i
);
  import wdt_pkg::*;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> !rst_req_i);                                  // R8
  AST_REQ_WITH_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> second_i);                                    // R8
  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(second_i) |-> $past(first_i));                        // R8
  AST_NOREBOOT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> !$past(no_reboot_i));                         // R9
  AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !reload_i) |=> $stable(cnt_i));                  // R3
  AST_INIT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i >= CNT_W'(MIN_INIT));                                // R5
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_req_i   (rst_req_o),
  .halt_i      (halt_q),
  .no_reboot_i (no_reboot_q),
  .reload_i    (reload_req),
  .first_i     (sts.first),
  .second_i    (sts.second),
  .cnt_i       (cnt),
  .init_i      (init_q)
);

// File: tb/sim_wdt_two_stage.sv
`timescale 1ns/100ps
module sim_wdt_two_stage;
  localparam int T = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rst_req;

  always #2.5 clk = ~clk;

  wdt_two_stage #(.TICK_CYCLES(T), .WIDE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req)
  );

  int n_chk = 0, n_fail = 0, n_pulse = 0;

  // behavioural reference state
  int m_cnt = 4, m_init = 4, m_pc = 0;
  bit m_halt = 1, m_nr = 1, m_s1 = 0, m_s2 = 0, m_boot = 0, m_req = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (rst_n) begin
    bit tk, rl, ex, hit, n1, n2, nb;
    rl  = we && addr == 5'h00 && wdata == 16'h0001;
    tk  = !m_halt && m_pc == T - 1;
    ex  = tk && !rl && m_cnt == 0;
    hit = ex && m_s1;
    n1 = (m_s1 && !(we && addr == 5'h04 && wdata[3])) || (ex && !m_s1);
    n2 = (m_s2 && !(we && addr == 5'h06 && wdata[1])) || hit;
    nb = (m_boot && !(we && addr == 5'h06 && wdata[2])) || (hit && !m_nr);
    m_req = hit && !m_nr;
    m_s1 = n1; m_s2 = n2; m_boot = nb;
    if (rl || ex) m_cnt = m_init;
    else if (tk) m_cnt = m_cnt - 1;
    if (m_halt || tk) m_pc = 0; else m_pc = m_pc + 1;
    if (we && addr == 5'h12 && int'(wdata[9:0]) >= 4) m_init = int'(wdata[9:0]);
    if (we && addr == 5'h08) begin m_halt = wdata[11]; m_nr = wdata[0]; end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    #1;
    chk("R8 rst_req", int'(rst_req), int'(m_req));
    if (rst_req) n_pulse++;
    if (!we && addr == 5'h00) chk("R2 live count", int'(rdata), m_cnt);
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 5'h00;
  endtask

  task automatic rd(input logic [4:0] a, input int exp, input string req);
    @(negedge clk); we = 1'b0; addr = a; #1;
    chk(req, int'(rdata), exp);
  endtask

  task automatic idle(input int n);
    @(negedge clk); addr = 5'h00;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int p0, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h08, 16'h0801, "R1 ctrl");
    rd(5'h00, 4, "R1 count");
    rd(5'h12, 4, "R1 init");
    rd(5'h04, 0, "R1 sts1");
    rd(5'h06, 0, "R1 sts2");
    chk("R1 rst_req", int'(rst_req), 0);

    // R5 refused and accepted initial values
    wr(5'h12, 16'h0003); rd(5'h12, 4, "R5 refuse 3");
    wr(5'h12, 16'h0000); rd(5'h12, 4, "R5 refuse 0");
    wr(5'h12, 16'hFC05); rd(5'h12, 5, "R5 field only");
    wr(5'h12, 16'h0006); rd(5'h12, 6, "R5 accept 6");

    // R4 reload key
    wr(5'h00, 16'h0002); rd(5'h00, 4, "R4 non-key ignored");
    wr(5'h00, 16'h0001); rd(5'h00, 6, "R4 key reloads");

    // R2/R6 run to first expiry
    wr(5'h08, 16'h0001);
    rd(5'h08, 16'h0001, "R3 ctrl readback");
    idle(1);
    for (int i = 0; i < 2000 && !m_s1; i++) @(negedge clk);
    rd(5'h04, 16'h0008, "R6 first timeout");
    wr(5'h04, 16'h0000); rd(5'h04, 16'h0008, "R7 write 0 keeps");
    wr(5'h04, 16'h0008); rd(5'h04, 0, "R7 write 1 clears");

    // R9 second expiry with no-reboot set
    p0 = n_pulse;
    idle(1);
    for (int i = 0; i < 4000 && !m_s2; i++) @(negedge clk);
    idle(3);
    chk("R9 no pulse", n_pulse - p0, 0);
    rd(5'h06, 16'h0002, "R9 second recorded");
    wr(5'h06, 16'h0002); rd(5'h06, 0, "R7 second cleared");

    // R8/R10 second expiry with reboot allowed
    wr(5'h04, 16'h0008);
    wr(5'h08, 16'h0000);
    p0 = n_pulse;
    idle(1);
    for (int i = 0; i < 4000 && !m_s2; i++) @(negedge clk);
    idle(2);
    wr(5'h08, 16'h0800);
    chk("R8 one pulse", n_pulse - p0, 1);
    rd(5'h06, 16'h0006, "R10 boot set");
    wr(5'h06, 16'h0004); rd(5'h06, 16'h0002, "R10 boot cleared");
    wr(5'h06, 16'h0002); rd(5'h06, 0, "R7 second cleared again");

    // R3 halt freezes count
    @(negedge clk); addr = 5'h00; #1; held = int'(rdata);
    idle(20);
    rd(5'h00, held, "R3 halted count");

    // R4 reload on the expiring edge wins
    wr(5'h04, 16'h0008);
    wr(5'h12, 16'h0004);
    wr(5'h00, 16'h0001);
    wr(5'h08, 16'h0001);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!m_halt && m_cnt == 0 && m_pc == T - 1) break;
    end
    addr = 5'h00; wdata = 16'h0001; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(5'h04, 0, "R4 reload beats expiry");
    rd(5'h00, 4, "R4 count after reload");
    idle(10);

    finish_run();
  end
endmodule